// File: doc/BRIEF.md
# Thyristor Ramp-Comparator Firing Generator

This block produces the gate pulses for a pair of anti-parallel thyristors. A sampled sign bit of the synchronizing fundamental waveform comes in on every sample strobe. The block filters it against chatter and detects the low-to-high transitions. Each accepted rising transition restarts a phase ramp that climbs from 0 to full scale (360 degrees) over one line cycle.

The ramp is compared with a requested delay angle to fire the forward device. The same ramp is compared with that angle plus half of full scale to fire the reverse device. Each firing issues a pulse of fixed width, counted in samples. A block command and a bypass command override the comparison result at the gate outputs.

Phase is an unsigned word where `FULL` counts stand for 360 degrees. The phase step per sample, the pulse width and the filter length are parameters. Their defaults give one full ramp per 60 Hz period and a 1 ms pulse at the default sample rate. All state advances only on clock edges where `strobe` is high.

Top module: `thy_fire_gen`

## Requirements
- R1: The sign input is accepted as changed only after it has differed from the last accepted level on `STABLE_N` consecutive strobed samples. Only an accepted low-to-high change (0 to 1) counts as a synchronizing crossing, and falling changes have no effect on the ramp. The accepted level is 1 after reset.
- R2: On the strobe that accepts a crossing, the phase output becomes 0. On each later strobe it grows by `STEP` and saturates at `FULL`. Between strobes it holds.
- R3: The forward gate fires on the first strobe after a crossing at which the phase (as registered before that strobe) is at least the latched delay angle. It fires at most once per ramp. Its pulse is high for exactly `PW_SAMPLES` strobe intervals, whatever the angle.
- R4: When the latched angle plus `FULL/2` is below `FULL`, the reverse gate fires in the same ramp, on the first strobe at which the phase is at least that sum. Its pulse width is the same as in R3.
- R5: When the latched angle plus `FULL/2` is `FULL` or more, the reverse pulse is instead issued in the following ramp, at phase (angle + `FULL/2` - `FULL`). A carried target takes precedence over that ramp's own unwrapped target, so at most one reverse pulse is issued per ramp.
- R6: The delay angle input is latched only on the crossing strobe. Changes during a ramp take effect at the next crossing. Values above `FULL-1` are treated as `FULL-1`.
- R7: A firing that has not happened when the next crossing is accepted is dropped. No pulse is started on a crossing strobe.
- R8: While `block` is high, both gate outputs are low, whether or not `bypass` is also high.
- R9: While `bypass` is high and `block` is low, both gate outputs are high.
- R10: After reset the phase reads `FULL` and no gate pulse is issued before the first accepted crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Sample strobe, one clock wide per sample |
| sign_in | input | 1 | Sign of the synchronizing waveform (1 = positive) |
| alpha_in | input | PH_W | Requested delay angle in phase counts |
| block | input | 1 | Forces both gates off |
| bypass | input | 1 | Forces both gates on (when not blocked) |
| gate_fwd | output | 1 | Forward device gate |
| gate_rev | output | 1 | Reverse device gate |
| phase | output | PH_W | Current ramp phase |

## Verification
The assertions take the sign and angle inputs to be synchronous to the clock and sampled only on strobes. They allow block and bypass to change at any clock. Nothing is assumed about the waveform period: a ramp that ends before a target is reached simply loses that firing. The stimulus changes inputs only on the falling clock edge. It uses sign runs of at least `STABLE_N` samples except for deliberate single-sample blips, and it resets the block between runs so each expected schedule starts from the documented reset state.

// File: rtl/thy_fire_pkg.sv
package thy_fire_pkg;
    localparam int NUM_GATES = 2;
    localparam int GATE_FWD  = 0;
    localparam int GATE_REV  = 1;
endpackage

// File: rtl/thy_zc_detect.sv
module thy_zc_detect #(
    parameter int STABLE_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sign_in,
    output logic rise
);
    localparam int CW = (STABLE_N < 2) ? 1 : $clog2(STABLE_N + 1);

    typedef struct packed {
        logic          acc;
        logic [CW-1:0] run;
    } zc_t;

    zc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        if (strobe) begin
            if (sign_in == st_q.acc) begin
                st_d.run = '0;
            end else if (st_q.run == CW'(STABLE_N - 1)) begin
                st_d.acc = sign_in;
                st_d.run = '0;
                rise     = sign_in;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= 1'b1;
            st_q.run <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/thy_phase_ramp.sv
module thy_phase_ramp #(
    parameter int PH_W = 16,
    parameter int FULL = 23040,
    parameter int STEP = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic            rise,
    input  logic [PH_W-1:0] alpha_in,
    output logic [PH_W-1:0] phase,
    output logic [1:0]      fire
);
    localparam int HALF = FULL / 2;
    localparam logic [PH_W:0] FULL_X = (PH_W+1)'(FULL);
    localparam logic [PH_W:0] HALF_X = (PH_W+1)'(HALF);
    localparam logic [PH_W:0] STEP_X = (PH_W+1)'(STEP);
    localparam logic [PH_W-1:0] TOP_A = PH_W'(FULL - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [PH_W-1:0] alpha;
        logic            fwd_pend;
        logic            rev_arm;
        logic [PH_W-1:0] rev_tgt;
        logic            carry_v;
        logic [PH_W-1:0] carry_tgt;
    } ramp_t;

    ramp_t st_d, st_q;

    logic [PH_W-1:0] a_clamp;
    logic [PH_W:0]   rev_sum;
    logic [PH_W:0]   ph_next;

    always_comb begin
        a_clamp = (alpha_in > TOP_A) ? TOP_A : alpha_in;
        rev_sum = {1'b0, a_clamp} + HALF_X;
        ph_next = {1'b0, st_q.phase} + STEP_X;
        st_d    = st_q;
        fire    = 2'b00;
        if (strobe) begin
            if (rise) begin
                st_d.phase    = '0;
                st_d.alpha    = a_clamp;
                st_d.fwd_pend = 1'b1;
                if (st_q.carry_v) begin
                    st_d.rev_arm = 1'b1;
                    st_d.rev_tgt = st_q.carry_tgt;
                end else if (rev_sum < FULL_X) begin
                    st_d.rev_arm = 1'b1;
                    st_d.rev_tgt = PH_W'(rev_sum);
                end else begin
                    st_d.rev_arm = 1'b0;
                end
                st_d.carry_v   = (rev_sum >= FULL_X);
                st_d.carry_tgt = PH_W'(rev_sum - FULL_X);
            end else begin
                st_d.phase = (ph_next > FULL_X) ? PH_W'(FULL) : PH_W'(ph_next);
                if (st_q.fwd_pend && (st_q.phase >= st_q.alpha)) begin
                    fire[0]       = 1'b1;
                    st_d.fwd_pend = 1'b0;
                end
                if (st_q.rev_arm && (st_q.phase >= st_q.rev_tgt)) begin
                    fire[1]      = 1'b1;
                    st_d.rev_arm = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_W'(FULL);
            st_q.alpha     <= '0;
            st_q.fwd_pend  <= 1'b0;
            st_q.rev_arm   <= 1'b0;
            st_q.rev_tgt   <= '0;
            st_q.carry_v   <= 1'b0;
            st_q.carry_tgt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
endmodule

// File: rtl/thy_gate_pulse.sv
module thy_gate_pulse #(
    parameter int PW_SAMPLES = 1382
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(PW_SAMPLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (strobe) begin
            if (fire) begin
                cnt_d = CW'(PW_SAMPLES);
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/thy_fire_gen.sv
module thy_fire_gen
    import thy_fire_pkg::*;
#(
    parameter int PH_W       = 16,
    parameter int FULL       = 23040,
    parameter int SAMPLE_HZ  = 1382400,
    parameter int LINE_HZ    = 60,
    parameter int STEP       = FULL * LINE_HZ / SAMPLE_HZ,
    parameter int PW_SAMPLES = SAMPLE_HZ / 1000,
    parameter int STABLE_N   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic            sign_in,
    input  logic [PH_W-1:0] alpha_in,
    input  logic            block,
    input  logic            bypass,
    output logic            gate_fwd,
    output logic            gate_rev,
    output logic [PH_W-1:0] phase
);
    logic                 rise;
    logic [1:0]           fire;
    logic [NUM_GATES-1:0] raw;

    thy_zc_detect #(.STABLE_N(STABLE_N)) u_zc (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .sign_in(sign_in), .rise(rise)
    );

    thy_phase_ramp #(.PH_W(PH_W), .FULL(FULL), .STEP(STEP)) u_ramp (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .rise(rise),
        .alpha_in(alpha_in), .phase(phase), .fire(fire)
    );

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_pulse
        thy_gate_pulse #(.PW_SAMPLES(PW_SAMPLES)) u_pw (
            .clk(clk), .rst_n(rst_n), .strobe(strobe),
            .fire(fire[g]), .active(raw[g])
        );
    end

    assign gate_fwd = !block && (bypass || raw[GATE_FWD]);
    assign gate_rev = !block && (bypass || raw[GATE_REV]);
endmodule

// File: rtl/thy_fire_chk.sv
module thy_fire_chk #(
    parameter int PH_W = 16,
    parameter int FULL = 23040
) (
    input logic            clk,
    input logic            rst_n,
    input logic            strobe,
    input logic            sign_in,
    input logic            block,
    input logic            bypass,
    input logic            gate_fwd,
    input logic            gate_rev,
    input logic [PH_W-1:0] phase,
    input logic            rise,
    input logic [1:0]      fire
);
    logic fwd_seen, rev_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_seen <= 1'b0;
            rev_seen <= 1'b0;
        end else if (strobe && rise) begin
            fwd_seen <= 1'b0;
            rev_seen <= 1'b0;
        end else begin
            if (fire[0]) fwd_seen <= 1'b1;
            if (fire[1]) rev_seen <= 1'b1;
        end
    end

    // R1
    rise_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (strobe && sign_in));
    // R2
    phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rise) |=> (phase == '0));
    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(phase));
    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_W'(FULL));
    // R3
    fwd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire[0] |-> !fwd_seen);
    // R5
    rev_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |-> !rev_seen);
    // R7
    no_fire_on_xing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (fire == 2'b00));
    // R8
    block_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block |-> (!gate_fwd && !gate_rev));
    // R9
    bypass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !block) |-> (gate_fwd && gate_rev));
endmodule

bind thy_fire_gen thy_fire_chk #(.PH_W(PH_W), .FULL(FULL)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sign_in(sign_in),
    .block(block), .bypass(bypass), .gate_fwd(gate_fwd), .gate_rev(gate_rev),
    .phase(phase), .rise(rise), .fire(fire)
);

// File: tb/thy_fire_gen_test.sv
module thy_fire_gen_test;
    localparam int PH_W = 6;
    localparam int FULL = 40;
    localparam int HALF = FULL / 2;
    localparam int STEP = 1;
    localparam int PW   = 3;
    localparam int SN   = 2;
    localparam int T    = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic sign_in = 1'b0;
    logic [PH_W-1:0] alpha_in = '0;
    logic block = 1'b0;
    logic bypass = 1'b0;
    logic gate_fwd, gate_rev;
    logic [PH_W-1:0] phase;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int sig [T];
    int alp [T];
    int xg  [T];
    int eph [T];
    int ef  [T];
    int er  [T];
    int kx  [T];

    always #2 clk = ~clk;

    thy_fire_gen #(
        .PH_W(PH_W), .FULL(FULL), .STEP(STEP),
        .PW_SAMPLES(PW), .STABLE_N(SN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .sign_in(sign_in),
        .alpha_in(alpha_in), .block(block), .bypass(bypass),
        .gate_fwd(gate_fwd), .gate_rev(gate_rev), .phase(phase)
    );

    function automatic int sig_of(int typ, int n);
        int p;
        int b;
        case (typ)
            1:       return ((n % 30) >= 15) ? 1 : 0;
            2:       return ((n % 52) >= 26) ? 1 : 0;
            3: begin
                p = n % 40;
                b = (p >= 20) ? 1 : 0;
                if (p == 5 || p == 30) b = 1 - b;
                return b;
            end
            default: return ((n % 40) >= 20) ? 1 : 0;
        endcase
    endfunction

    function automatic int blk_of(int n);
        return ((n % 11) == 4) ? 1 : 0;
    endfunction

    function automatic int byp_of(int n);
        return ((n % 7) == 2) ? 1 : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input int n);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s sample %0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    task automatic mark(ref int arr [T], input int f);
        for (int q = f; q < f + PW; q++)
            if (q >= 0 && q < T) arr[q] = 1;
    endtask

    // expected schedule from R1, R2, R5, R6, R7
    task automatic build(input int typ, input int a1, input int a2, input int chg);
        int acc, rc, m, ph, started, nxt, a, s, ps, pv, t, en;
        acc = 1; rc = 0; m = 0; ph = FULL; started = 0;
        for (int n = 0; n < T; n++) begin
            sig[n] = sig_of(typ, n);
            alp[n] = (n < chg) ? a1 : a2;
            xg[n] = 0; ef[n] = 0; er[n] = 0;
            if (sig[n] == acc) rc = 0;
            else if (rc == SN - 1) begin
                acc = sig[n]; rc = 0;
                if (acc == 1) begin xg[n] = 1; kx[m] = n; m++; end
            end else rc++;
            if (xg[n] == 1) begin ph = 0; started = 1; end
            else if (started == 1) begin
                nxt = ph + STEP;
                ph = (nxt > FULL) ? FULL : nxt;
            end
            eph[n] = ph;
        end
        pv = 0; ps = 0;
        for (int i = 0; i < m; i++) begin
            en = (i + 1 < m) ? kx[i+1] : T + 1000;
            a = (alp[kx[i]] > FULL - 1) ? FULL - 1 : alp[kx[i]];
            t = kx[i] + 1 + (a + STEP - 1) / STEP;
            if (t < en) mark(ef, t);
            s = a + HALF;
            if (pv == 1) t = ps - FULL;
            else if (s < FULL) t = s;
            else t = -1;
            if (t >= 0) begin
                t = kx[i] + 1 + (t + STEP - 1) / STEP;
                if (t < en) mark(er, t);
            end
            pv = (s >= FULL) ? 1 : 0;
            ps = s;
        end
    endtask

    task automatic run_case(input int typ, input int a1, input int a2, input int chg,
                            input string tag);
        int ef_x, er_x;
        string gt;
        build(typ, a1, a2, chg);
        @(negedge clk);
        rst_n = 1'b0; strobe = 1'b0; block = 1'b0; bypass = 1'b0; sign_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n < T; n++) begin
            sign_in  = sig[n][0];
            alpha_in = PH_W'(alp[n]);
            block    = blk_of(n)[0];
            bypass   = byp_of(n)[0];
            strobe   = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            if (blk_of(n) == 1) begin
                ef_x = 0; er_x = 0; gt = "R8";
            end else if (byp_of(n) == 1) begin
                ef_x = 1; er_x = 1; gt = "R9";
            end else begin
                ef_x = ef[n]; er_x = er[n]; gt = tag;
            end
            check({"R2 phase ", tag}, int'(phase), eph[n], n);
            check({"R3 gate_fwd ", gt}, int'(gate_fwd), ef_x, n);
            check({"R4 gate_rev ", gt}, int'(gate_rev), er_x, n);
            @(negedge clk);
        end
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 phase after reset", int'(phase), FULL, 0);
        check("R10 gate_fwd after reset", int'(gate_fwd), 0, 0);
        check("R10 gate_rev after reset", int'(gate_rev), 0, 0);
        rst_n = 1'b1;
        // R3 R4 R5: full alpha sweep, ramp length equal to full scale
        for (int a = 0; a < FULL; a++) run_case(0, a, a, T, (a < HALF) ? "R4" : "R5");
        // R7: short line period drops late firings
        run_case(1, 0, 0, T, "R7");
        run_case(1, 10, 10, T, "R7");
        run_case(1, 25, 25, T, "R7");
        run_case(1, 39, 39, T, "R7");
        // R2: long period, ramp saturates
        run_case(2, 0, 0, T, "R2");
        run_case(2, 30, 30, T, "R2");
        run_case(2, 39, 39, T, "R2");
        // R1: single-sample chatter is ignored
        run_case(3, 7, 7, T, "R1");
        run_case(3, 27, 27, T, "R1");
        // R6: mid-ramp angle change, and clamping
        run_case(0, 5, 15, 70, "R6");
        run_case(0, 25, 35, 70, "R6");
        run_case(0, 15, 30, 70, "R6");
        run_case(0, 30, 12, 70, "R6");
        run_case(0, 63, 63, T, "R6");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule